// File: doc/BRIEF.md
# Micro-op Parallel-Load Sequencing Queue

This block decouples an instruction translator, which breaks each complex instruction into up to four simple micro-ops, from a single-issue decode stage that takes one micro-op per cycle. In one cycle the translator writes a whole group in parallel, one micro-op into each of four lane FIFOs. Lanes that the translator leaves unused get a no-op entry. The decode stage then reads the oldest group one lane at a time, starting at lane 0.

Each micro-op has an end-of-instruction flag. When a popped micro-op has this flag set, the reader drops the rest of that group and moves to lane 0 of the next group. If lane 3 is popped without the flag, the reader also moves to lane 0 of the next group, so one instruction can span several groups. A flush input clears the queue in one cycle. It is used when a branch is taken or an interrupt arrives. A full output stalls the translator until every lane has room for another group.

Top module: `uop_seq_queue`

## Requirements
- R1: A push (`push_valid` high while `full` is low and `flush` is low) stores, in a single cycle, the payload and end flag of every lane whose bit in `push_mask` is set. Lane i payload is `push_payload[i*PAYLOAD_W +: PAYLOAD_W]` and its flag is `push_eoi[i]`.
- R2: A lane whose `push_mask` bit is clear stores a no-op in that group: a payload of all zeros and a clear end flag. Whatever is on that lane's payload and flag inputs is ignored.
- R3: Pops take the lanes of a group in the order 0, 1, 2, 3. `pop_lane` gives the lane index (0 to 3) of the micro-op now on `pop_payload`.
- R4: After a pop whose `pop_eoi` is 1, the next micro-op offered is lane 0 of the next group. The later lanes of the popped group are never offered.
- R5: `full` is 1 exactly when DEPTH groups are held. A push attempted while `full` is 1 is ignored, and no group already held is lost.
- R6: A cycle with `flush` high empties every lane and returns `pop_lane` to 0. A push in the same cycle is dropped, so in the next cycle `pop_valid` is 0.
- R7: `pop_valid` is 0 whenever no group is held. While `pop_valid` is 1 and `pop_ready` is 0, `pop_payload`, `pop_eoi` and `pop_lane` hold their values.
- R8: After a pop from lane 3 with `pop_eoi` of 0, the next micro-op offered is lane 0 of the next group.
- R9: After reset, `pop_valid` is 0, `full` is 0 and `pop_lane` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Clears the whole queue; takes priority over a push |
| push_valid | input | 1 | Translator offers a group |
| push_mask | input | LANES | Lanes that carry a real micro-op |
| push_payload | input | LANES*PAYLOAD_W | Micro-op words; lane i is at bits i*PAYLOAD_W upward |
| push_eoi | input | LANES | End-of-instruction flag for each lane |
| full | output | 1 | No room for another group; stalls the translator |
| pop_valid | output | 1 | A micro-op is offered |
| pop_ready | input | 1 | Decode stage takes the offered micro-op |
| pop_payload | output | PAYLOAD_W | Offered micro-op word |
| pop_eoi | output | 1 | End flag of the offered micro-op |
| pop_lane | output | $clog2(LANES) | Lane the offered micro-op comes from |

## Verification
The sequencing is tried with four group shapes:
- A full four-lane group ending at lane 3. This shows in-order lane traversal.
- A two-lane group with its flag on lane 1. This shows that the early restart skips lanes that still hold data.
- A group with gaps in its mask. This shows that no-op filling replaces the inputs on unused lanes.
- A flagless single-lane group followed by a second group. This shows the roll-over from lane 3 into the next group.

The queue is filled to depth with an extra push pending, to show that the stall holds groups back without dropping any. A flush is applied in the middle of a group while a push is offered in the same cycle. A held-off reader confirms that the output stays stable while it waits.

// File: rtl/uopq_pkg.sv
package uopq_pkg;
   // payload widths of the three micro-op encodings (6-bit field included)
   localparam int UOP_FMT_A_W = 21;
   localparam int UOP_FMT_B_W = 24;
   localparam int UOP_FMT_C_W = 27;

   function automatic int widest_fmt();
      int w;
      w = UOP_FMT_A_W;
      if (UOP_FMT_B_W > w) w = UOP_FMT_B_W;
      if (UOP_FMT_C_W > w) w = UOP_FMT_C_W;
      return w;
   endfunction

   localparam int UOP_MAX_W     = widest_fmt();
   localparam int UOPQ_LANES    = 4;
   localparam int UOPQ_DEPTH    = 4;
endpackage

// File: rtl/uopq_lane_fifo.sv
module uopq_lane_fifo #(
   parameter int ENTRY_W = 28,
   parameter int DEPTH   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               wr,
   input  logic [ENTRY_W-1:0] wdata,
   input  logic               rd,
   output logic [ENTRY_W-1:0] rdata,
   output logic               empty,
   output logic               full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 1) begin : g_bad_depth
      $error("uopq_lane_fifo: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      // one slot: a register with an occupancy bit
      logic               occ;
      logic [ENTRY_W-1:0] slot;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   occ <= 1'b0;
         else if (clr) occ <= 1'b0;
         else if (wr)  occ <= 1'b1;
         else if (rd)  occ <= 1'b0;
      end

      always_ff @(posedge clk) begin
         if (wr && !clr) slot <= wdata;
      end

      assign rdata = slot;
      assign empty = !occ;
      assign full  = occ;
   end else begin : g_ring
      // ring buffer with one wrap bit on each pointer
      logic [AW:0]        wp, rp;
      logic [ENTRY_W-1:0] mem [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wp <= '0;
            rp <= '0;
         end else if (clr) begin
            wp <= '0;
            rp <= '0;
         end else begin
            if (wr) wp <= wp + (AW+1)'(1);
            if (rd) rp <= rp + (AW+1)'(1);
         end
      end

      always_ff @(posedge clk) begin
         if (wr && !clr) mem[wp[AW-1:0]] <= wdata;
      end

      assign rdata = mem[rp[AW-1:0]];
      assign empty = (wp == rp);
      assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   end
endmodule

// File: rtl/uopq_rd_seq.sv
module uopq_rd_seq #(
   parameter int LANES = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic                     pop_fire,
   input  logic                     head_eoi,
   output logic [$clog2(LANES)-1:0] rd_lane,
   output logic                     retire
);
   localparam int LANE_W = $clog2(LANES);
   localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

   // a group leaves when its flagged uop or its last lane is taken
   assign retire = pop_fire && (head_eoi || (rd_lane == LAST_LANE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rd_lane <= '0;
      else if (flush)    rd_lane <= '0;
      else if (retire)   rd_lane <= '0;
      else if (pop_fire) rd_lane <= rd_lane + LANE_W'(1);
   end
endmodule

// File: rtl/uop_seq_queue.sv
module uop_seq_queue #(
   parameter int LANES     = uopq_pkg::UOPQ_LANES,
   parameter int DEPTH     = uopq_pkg::UOPQ_DEPTH,
   parameter int PAYLOAD_W = uopq_pkg::UOP_MAX_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       push_valid,
   input  logic [LANES-1:0]           push_mask,
   input  logic [LANES*PAYLOAD_W-1:0] push_payload,
   input  logic [LANES-1:0]           push_eoi,
   output logic                       full,
   output logic                       pop_valid,
   input  logic                       pop_ready,
   output logic [PAYLOAD_W-1:0]       pop_payload,
   output logic                       pop_eoi,
   output logic [$clog2(LANES)-1:0]   pop_lane
);
   localparam int LANE_W  = $clog2(LANES);
   localparam int ENTRY_W = PAYLOAD_W + 1;

   if (PAYLOAD_W < uopq_pkg::UOP_MAX_W) begin : g_bad_width
      $error("uop_seq_queue: PAYLOAD_W narrower than the widest micro-op");
   end
   if (LANES < 2) begin : g_bad_lanes
      $error("uop_seq_queue: LANES must be at least 2");
   end
   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("uop_seq_queue: DEPTH must be a power of two");
   end

   logic               push_ok;
   logic               pop_fire;
   logic               retire;
   logic [LANE_W-1:0]  rd_lane;
   logic [LANES-1:0]   lane_empty;
   logic [LANES-1:0]   lane_full;
   logic [ENTRY_W-1:0] lane_rdata [LANES];
   logic [ENTRY_W-1:0] head;

   assign push_ok  = push_valid && !full && !flush;
   assign full     = |lane_full;
   assign pop_valid = ~|lane_empty;
   assign pop_fire = pop_valid && pop_ready;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [ENTRY_W-1:0] wentry;
      // unused lanes become a no-op: zero payload, flag clear
      assign wentry = push_mask[i]
                    ? {push_eoi[i], push_payload[i*PAYLOAD_W +: PAYLOAD_W]}
                    : '0;

      uopq_lane_fifo #(
         .ENTRY_W (ENTRY_W),
         .DEPTH   (DEPTH)
      ) i_fifo (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (flush),
         .wr    (push_ok),
         .wdata (wentry),
         .rd    (retire && !flush),
         .rdata (lane_rdata[i]),
         .empty (lane_empty[i]),
         .full  (lane_full[i])
      );
   end

   always_comb begin
      head = lane_rdata[0];
      for (int i = 1; i < LANES; i++) begin
         if (rd_lane == LANE_W'(i)) head = lane_rdata[i];
      end
   end

   uopq_rd_seq #(
      .LANES (LANES)
   ) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .pop_fire (pop_fire),
      .head_eoi (head[ENTRY_W-1]),
      .rd_lane  (rd_lane),
      .retire   (retire)
   );

   assign pop_payload = head[PAYLOAD_W-1:0];
   assign pop_eoi     = head[ENTRY_W-1];
   assign pop_lane    = rd_lane;
endmodule

// File: rtl/uop_seq_queue_chk.sv
module uop_seq_queue_chk #(
   parameter int LANES     = 4,
   parameter int DEPTH     = 4,
   parameter int PAYLOAD_W = 27
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     flush,
   input logic                     push_valid,
   input logic                     full,
   input logic                     pop_valid,
   input logic                     pop_ready,
   input logic [PAYLOAD_W-1:0]     pop_payload,
   input logic                     pop_eoi,
   input logic [$clog2(LANES)-1:0] pop_lane
);
   localparam int LANE_W = $clog2(LANES);
   localparam int CNT_W  = $clog2(DEPTH + 1) + 1;
   localparam logic [LANE_W-1:0] LAST = LANE_W'(LANES - 1);

   logic             fire, leave, enter;
   logic [CNT_W-1:0] groups;

   assign fire  = pop_valid && pop_ready;
   assign leave = fire && (pop_eoi || pop_lane == LAST);
   assign enter = push_valid && !full;

   // independent group count seen from the ports
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     groups <= '0;
      else if (flush) groups <= '0;
      else            groups <= groups + CNT_W'(enter) - CNT_W'(leave);
   end

   a_r5_full_at_depth: assert property (@(posedge clk) disable iff (!rst_n)
      full == (groups == CNT_W'(DEPTH)));

   a_r7_no_valid_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (groups == '0) |-> !pop_valid);

   a_r7_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_valid && !pop_ready && !flush) |=>
         (pop_valid && $stable(pop_payload) && $stable(pop_eoi) && $stable(pop_lane)));

   a_r3_lane_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !pop_eoi && pop_lane != LAST && !flush) |=>
         (pop_lane == $past(pop_lane) + LANE_W'(1)));

   a_r4_restart_after_eoi: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && pop_eoi) |=> (pop_lane == '0));

   a_r8_wrap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && pop_lane == LAST) |=> (pop_lane == '0));

   a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!pop_valid && pop_lane == '0 && !full));

   a_r1_push_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && !full && !flush) |=> pop_valid);
endmodule

bind uop_seq_queue uop_seq_queue_chk #(
   .LANES     (LANES),
   .DEPTH     (DEPTH),
   .PAYLOAD_W (PAYLOAD_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .flush       (flush),
   .push_valid  (push_valid),
   .full        (full),
   .pop_valid   (pop_valid),
   .pop_ready   (pop_ready),
   .pop_payload (pop_payload),
   .pop_eoi     (pop_eoi),
   .pop_lane    (pop_lane)
);

// File: tb/test_uop_seq_queue.sv
module test_uop_seq_queue;
   localparam int LANES = 4;
   localparam int DEPTH = 4;
   localparam int PW    = 27;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            flush = 1'b0;
   logic            push_valid = 1'b0;
   logic [LANES-1:0] push_mask = '0;
   logic [LANES*PW-1:0] push_payload = '0;
   logic [LANES-1:0] push_eoi = '0;
   logic            full;
   logic            pop_valid;
   logic            pop_ready = 1'b0;
   logic [PW-1:0]   pop_payload;
   logic            pop_eoi;
   logic [1:0]      pop_lane;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   uop_seq_queue #(.LANES(LANES), .DEPTH(DEPTH), .PAYLOAD_W(PW)) i_uop_seq_queue (
      .clk(clk), .rst_n(rst_n), .flush(flush), .push_valid(push_valid),
      .push_mask(push_mask), .push_payload(push_payload), .push_eoi(push_eoi),
      .full(full), .pop_valid(pop_valid), .pop_ready(pop_ready),
      .pop_payload(pop_payload), .pop_eoi(pop_eoi), .pop_lane(pop_lane)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push_grp(input logic [3:0] mask, input logic [3:0] eoi,
                           input logic [PW-1:0] p0, p1, p2, p3);
      push_valid   = 1'b1;
      push_mask    = mask;
      push_eoi     = eoi;
      push_payload = {p3, p2, p1, p0};
      @(negedge clk);
      push_valid   = 1'b0;
      push_mask    = '0;
      push_eoi     = '0;
      push_payload = '0;
   endtask

   task automatic pop_expect(input string req, input logic [PW-1:0] pl,
                             input logic eoi, input logic [1:0] lane);
      check({req, " valid"}, 32'(pop_valid), 32'd1);
      check({req, " payload"}, 32'(pop_payload), 32'(pl));
      check({req, " eoi"}, 32'(pop_eoi), 32'(eoi));
      check({req, " lane"}, 32'(pop_lane), 32'(lane));
      pop_ready = 1'b1;
      @(negedge clk);
      pop_ready = 1'b0;
   endtask

   task automatic t_reset();
      check("R9 valid", 32'(pop_valid), 32'd0);
      check("R9 full", 32'(full), 32'd0);
      check("R9 lane", 32'(pop_lane), 32'd0);
   endtask

   task automatic t_full_group();
      push_grp(4'b1111, 4'b1000, 27'h0A1, 27'h0A2, 27'h0A3, 27'h0A4);
      pop_expect("R1/R3 l0", 27'h0A1, 1'b0, 2'd0);
      pop_expect("R3 l1", 27'h0A2, 1'b0, 2'd1);
      pop_expect("R3 l2", 27'h0A3, 1'b0, 2'd2);
      pop_expect("R3 l3", 27'h0A4, 1'b1, 2'd3);
      check("R7 empty after group", 32'(pop_valid), 32'd0);
   endtask

   task automatic t_eoi_short();
      push_grp(4'b1111, 4'b0010, 27'h0B1, 27'h0B2, 27'h7FFFFFF, 27'h5555555);
      push_grp(4'b1111, 4'b0001, 27'h0C1, 27'h0C2, 27'h0C3, 27'h0C4);
      pop_expect("R4 first", 27'h0B1, 1'b0, 2'd0);
      pop_expect("R4 flagged", 27'h0B2, 1'b1, 2'd1);
      pop_expect("R4 restart at lane0 of next group", 27'h0C1, 1'b1, 2'd0);
      check("R4 rest discarded", 32'(pop_valid), 32'd0);
   endtask

   task automatic t_noop_fill();
      push_grp(4'b0101, 4'b0110, 27'h0D1, 27'h3ABCDEF, 27'h0D3, 27'h0D4);
      pop_expect("R2 real l0", 27'h0D1, 1'b0, 2'd0);
      pop_expect("R2 gap is noop", 27'h0, 1'b0, 2'd1);
      pop_expect("R2 real l2", 27'h0D3, 1'b1, 2'd2);
      push_grp(4'b0001, 4'b0000, 27'h0E1, 27'h1, 27'h2, 27'h3);
      push_grp(4'b0001, 4'b0001, 27'h0F1, 27'h0, 27'h0, 27'h0);
      pop_expect("R8 l0", 27'h0E1, 1'b0, 2'd0);
      pop_expect("R2 noop l1", 27'h0, 1'b0, 2'd1);
      pop_expect("R2 noop l2", 27'h0, 1'b0, 2'd2);
      pop_expect("R2 noop l3", 27'h0, 1'b0, 2'd3);
      pop_expect("R8 continues next group", 27'h0F1, 1'b1, 2'd0);
      check("R8 empty", 32'(pop_valid), 32'd0);
   endtask

   task automatic t_full();
      for (int g = 1; g <= DEPTH; g++) begin
         check("R5 not full yet", 32'(full), 32'd0);
         push_grp(4'b0001, 4'b0001, PW'(32'h100 + g), 27'h0, 27'h0, 27'h0);
      end
      check("R5 full at depth", 32'(full), 32'd1);
      push_grp(4'b0001, 4'b0001, 27'h1FF, 27'h0, 27'h0, 27'h0);
      check("R5 still full", 32'(full), 32'd1);
      for (int g = 1; g <= DEPTH; g++) begin
         pop_expect("R5 kept group", PW'(32'h100 + g), 1'b1, 2'd0);
      end
      check("R5 extra push ignored", 32'(pop_valid), 32'd0);
   endtask

   task automatic t_flush();
      push_grp(4'b1111, 4'b1000, 27'h201, 27'h202, 27'h203, 27'h204);
      push_grp(4'b1111, 4'b1000, 27'h211, 27'h212, 27'h213, 27'h214);
      pop_expect("R6 pre-flush", 27'h201, 1'b0, 2'd0);
      check("R6 mid group lane", 32'(pop_lane), 32'd1);
      flush = 1'b1;
      push_grp(4'b0001, 4'b0001, 27'h2FF, 27'h0, 27'h0, 27'h0);
      flush = 1'b0;
      check("R6 valid low", 32'(pop_valid), 32'd0);
      check("R6 lane reset", 32'(pop_lane), 32'd0);
      check("R6 full low", 32'(full), 32'd0);
      push_grp(4'b0001, 4'b0001, 27'h221, 27'h0, 27'h0, 27'h0);
      pop_expect("R6 fresh after flush", 27'h221, 1'b1, 2'd0);
   endtask

   task automatic t_stall();
      push_grp(4'b0011, 4'b0010, 27'h301, 27'h302, 27'h0, 27'h0);
      for (int c = 0; c < 3; c++) begin
         check("R7 held valid", 32'(pop_valid), 32'd1);
         check("R7 held payload", 32'(pop_payload), 32'h301);
         check("R7 held lane", 32'(pop_lane), 32'd0);
         @(negedge clk);
      end
      pop_expect("R7 release l0", 27'h301, 1'b0, 2'd0);
      pop_expect("R7 release l1", 27'h302, 1'b1, 2'd1);
      check("R7 empty", 32'(pop_valid), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full_group();
      t_eoi_short();
      t_noop_fill();
      t_full();
      t_flush();
      t_stall();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule